// File: doc/BRIEF.md
# Charger Fault Protection Supervisor

This block sits beside the output-level negotiation logic of a fast-charging power adapter. It takes already-digitized flags from four analog comparators: output over-voltage, socket fault (the port is loaded while no portable device is attached), over-temperature and supply undervoltage. Each fault gets its own persistence delay, counted in ticks of a shared timebase. When a fault qualifies, the block raises a sticky fault-monitor output that drives the external shutdown circuit. It also latches the cause of the first fault.

The block also picks the over-voltage comparator threshold that matches the negotiated output level and the class setting. After every level change it blanks the over-voltage check so that the expected overshoot is not treated as a fault. It pulses the temperature-sense current source on and off, and over-temperature only counts while that source is on. Supply undervoltage acts as a second synchronous reset.

Top module: `chg_fault_sup`

## Requirements
- R1: After reset, `fault_o` is 0 and `cause_o` is 0 (none). `temp_en_o` is 1, because the temperature pulse starts in its on phase.
- R2: If `ov_flag_i` stays high, and the check is not blanked, for `OV_QUAL` consecutive ticks, `fault_o` rises at the clock edge that samples the last of those ticks, and `cause_o` becomes 1 (over-voltage).
- R3: A qualification count returns to zero in any cycle in which its fault flag is low. A flag that repeatedly drops before its delay expires never trips.
- R4: A pulse on `level_chg_i` blanks the over-voltage check for that cycle and for the next `OV_BLANK` ticks. While blanked, the over-voltage count is held at zero.
- R5: `thr_sel_o` follows `level_i` and `class_b_i` in the same cycle. Level 0 (5 V) gives code 0, level 1 (9 V) gives 1, level 2 (12 V) gives 2, level 3 (20 V) gives 3. Level 4 (continuous) gives 2 for class A and 3 for class B. Levels 5 to 7 give 0. Codes 0 to 3 stand for the 1.52 V, 1.72 V, 1.87 V and 2.28 V thresholds.
- R6: `sock_flag_i` high for `SOCK_QUAL` consecutive ticks trips the fault with `cause_o` = 2 (socket).
- R7: `ot_flag_i` counts only while `temp_en_o` is 1. It trips the fault with `cause_o` = 3 (over-temperature) after `OT_QUAL` consecutive ticks with the source on. The over-temperature count is zero while the source is off.
- R8: `temp_en_o` is high for `TEMP_ON` ticks, then low for `TEMP_OFF` ticks, and this repeats.
- R9: Once `fault_o` is high it stays high, and `cause_o` holds the first cause, until reset. When several faults trip on the same edge, the recorded cause follows the priority over-voltage, then over-temperature, then socket.
- R10: `uv_low_i` high acts as a synchronous reset of all state. While it is high, `temp_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uv_low_i | input | 1 | Supply below the undervoltage threshold |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| ov_flag_i | input | 1 | Output over-voltage comparator flag |
| sock_flag_i | input | 1 | Socket fault comparator flag |
| ot_flag_i | input | 1 | Over-temperature comparator flag |
| level_i | input | 3 | Active output level code |
| class_b_i | input | 1 | 1 = class B, 0 = class A |
| level_chg_i | input | 1 | One-cycle strobe on an output level change |
| fault_o | output | 1 | Fault-monitor shutdown drive |
| thr_sel_o | output | 2 | Over-voltage threshold select code |
| temp_en_o | output | 1 | Temperature-sense current source enable |
| cause_o | output | 2 | Latched first-fault cause |

## Verification
A qualification counter that fails to clear makes a string of short flag bursts end in a trip. That trip shows up at `fault_o` after the bursts add up to the limit, well before any single burst could reach it. A blanking counter that is wrong moves the over-voltage trip earlier or later, in steps of whole ticks, relative to the level strobe. A temperature phase counter that is wrong shows up at `temp_en_o` on the first phase boundary. The cause register is compared on every cycle, so a priority that is wrong or a cause that gets overwritten appears on the edge where it happens.

// File: rtl/chg_fault_pkg.sv
// Package: shared cause codes and the threshold mapping of the fault supervisor.
// Assumes level codes 0..3 = 5/9/12/20 V, 4 = continuous mode, 5..7 unused.
package chg_fault_pkg;

    typedef enum logic [1:0] {
        CZ_NONE     = 2'd0,
        CZ_OVERVOLT = 2'd1,
        CZ_SOCKET   = 2'd2,
        CZ_OVERTEMP = 2'd3
    } cause_t;

    localparam logic [2:0] LVL_CONT = 3'd4;

    // Threshold code for a level/class pair (codes rise with the threshold voltage).
    function automatic logic [1:0] thr_code(input logic [2:0] lvl, input logic cls_b);
        logic [1:0] code;
        case (lvl)
            3'd1:     code = 2'd1;
            3'd2:     code = 2'd2;
            3'd3:     code = 2'd3;
            LVL_CONT: code = cls_b ? 2'd3 : 2'd2;
            default:  code = 2'd0;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/chg_fault_qual.sv
// Qualification counter: counts ticks while a fault condition holds and flags
// a trip on the tick that completes LIMIT consecutive ticks.
// Assumes LIMIT >= 1. The count clears in any cycle where the condition is low.
module chg_fault_qual #(
    parameter int unsigned LIMIT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic tick_i,
    output logic trip_o
);
    localparam int unsigned W = $clog2(LIMIT) + 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Count consecutive ticks of the condition, saturating at the trip point.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (!cond_i)                   cnt_q <= '0;
        else if (tick_i && (cnt_q != TOP))  cnt_q <= cnt_q + 1'b1;
    end

    assign trip_o = cond_i && tick_i && (cnt_q == TOP);
endmodule

// File: rtl/chg_fault_blank.sv
// Blanking window: after a level-change strobe, masks the over-voltage check
// for the strobe cycle plus BLANK_TICKS timebase ticks.
// Assumes the strobe is one cycle wide. A new strobe restarts the window.
module chg_fault_blank #(
    parameter int unsigned BLANK_TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic tick_i,
    output logic blank_o
);
    localparam int unsigned W = $clog2(BLANK_TICKS + 1);
    localparam logic [W-1:0] LOAD = W'(BLANK_TICKS);

    logic [W-1:0] left_q;

    // Load the window on a strobe and drain it one tick at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)                        left_q <= '0;
        else if (chg_i)                    left_q <= LOAD;
        else if (tick_i && left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign blank_o = chg_i || (left_q != '0);
endmodule

// File: rtl/chg_fault_tpulse.sv
// Temperature-source pulser: on for ON_TICKS ticks, then off for OFF_TICKS
// ticks, repeating. It starts in the on phase after reset.
// Assumes both durations are >= 1.
module chg_fault_tpulse #(
    parameter int unsigned ON_TICKS  = 12000,
    parameter int unsigned OFF_TICKS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic on_o
);
    localparam int unsigned MAXT = (ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS;
    localparam int unsigned W = $clog2(MAXT) + 1;
    localparam logic [W-1:0] ON_END  = W'(ON_TICKS - 1);
    localparam logic [W-1:0] OFF_END = W'(OFF_TICKS - 1);

    logic         on_q;
    logic [W-1:0] ph_q;

    // Advance the phase counter on ticks and flip phase at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b1;
            ph_q <= '0;
        end else if (tick_i) begin
            if (on_q && ph_q == ON_END) begin
                on_q <= 1'b0;
                ph_q <= '0;
            end else if (!on_q && ph_q == OFF_END) begin
                on_q <= 1'b1;
                ph_q <= '0;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign on_o = on_q;
endmodule

// File: rtl/chg_fault_sup.sv
// Charger fault supervisor top. It qualifies the over-voltage, socket and
// over-temperature flags, latches a sticky fault with the first cause, maps
// level/class to an over-voltage threshold code and pulses the temperature
// source. Undervoltage acts as a synchronous reset. Durations are in ticks.
module chg_fault_sup
    import chg_fault_pkg::*;
#(
    parameter int unsigned OV_QUAL   = 50,
    parameter int unsigned OV_BLANK  = 500,
    parameter int unsigned SOCK_QUAL = 40000,
    parameter int unsigned OT_QUAL   = 1000,
    parameter int unsigned TEMP_ON   = 12000,
    parameter int unsigned TEMP_OFF  = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_low_i,
    input  logic       tick_i,
    input  logic       ov_flag_i,
    input  logic       sock_flag_i,
    input  logic       ot_flag_i,
    input  logic [2:0] level_i,
    input  logic       class_b_i,
    input  logic       level_chg_i,
    output logic       fault_o,
    output logic [1:0] thr_sel_o,
    output logic       temp_en_o,
    output logic [1:0] cause_o
);
    localparam int unsigned NCH = 3;   // 0 over-voltage, 1 socket, 2 over-temperature
    localparam int unsigned QLIM [NCH] = '{OV_QUAL, SOCK_QUAL, OT_QUAL};

    logic           run_n;
    logic           blanked;
    logic           src_on;
    logic [NCH-1:0] cond;
    logic [NCH-1:0] trip;
    logic           fault_q;
    cause_t         cause_q;
    cause_t         cause_d;

    // Combined synchronous reset: external reset or supply undervoltage.
    assign run_n = rst_n && !uv_low_i;

    chg_fault_blank #(.BLANK_TICKS(OV_BLANK)) u_blank (
        .clk(clk), .rst_n(run_n), .chg_i(level_chg_i), .tick_i(tick_i), .blank_o(blanked)
    );

    chg_fault_tpulse #(.ON_TICKS(TEMP_ON), .OFF_TICKS(TEMP_OFF)) u_tpulse (
        .clk(clk), .rst_n(run_n), .tick_i(tick_i), .on_o(src_on)
    );

    // Qualified conditions fed to the per-fault counters.
    assign cond[0] = ov_flag_i && !blanked;
    assign cond[1] = sock_flag_i;
    assign cond[2] = ot_flag_i && src_on;

    for (genvar i = 0; i < NCH; i++) begin : g_qual
        chg_fault_qual #(.LIMIT(QLIM[i])) u_qual (
            .clk(clk), .rst_n(run_n), .cond_i(cond[i]), .tick_i(tick_i), .trip_o(trip[i])
        );
    end

    // Priority encode the trips: over-voltage, then over-temperature, then socket.
    always_comb begin
        if (trip[0])      cause_d = CZ_OVERVOLT;
        else if (trip[2]) cause_d = CZ_OVERTEMP;
        else if (trip[1]) cause_d = CZ_SOCKET;
        else              cause_d = CZ_NONE;
    end

    // Latch the first fault and its cause until reset.
    always_ff @(posedge clk) begin
        if (!run_n) begin
            fault_q <= 1'b0;
            cause_q <= CZ_NONE;
        end else if (!fault_q && (trip != '0)) begin
            fault_q <= 1'b1;
            cause_q <= cause_d;
        end
    end

    assign fault_o   = fault_q;
    assign cause_o   = cause_q;
    assign thr_sel_o = thr_code(level_i, class_b_i);
    assign temp_en_o = src_on && run_n;
endmodule

// File: rtl/chg_fault_sup_chk.sv
// Checker for the charger fault supervisor: port-level temporal properties.
// Assumes it is bound to chg_fault_sup and sees the same clock and resets.
module chg_fault_sup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uv_low_i,
    input logic       ov_flag_i,
    input logic       sock_flag_i,
    input logic       ot_flag_i,
    input logic       fault_o,
    input logic       temp_en_o,
    input logic [1:0] cause_o
);
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n || uv_low_i)
        fault_o |=> fault_o);                                            // R9
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n || uv_low_i)
        fault_o |=> $stable(cause_o));                                   // R9
    AST_CAUSE_MATCHES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o == (cause_o != 2'd0));                                   // R1
    AST_OV_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n || uv_low_i)
        ($rose(fault_o) && cause_o == 2'd1) |-> $past(ov_flag_i));       // R2
    AST_SOCK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n || uv_low_i)
        ($rose(fault_o) && cause_o == 2'd2) |-> $past(sock_flag_i));     // R6
    AST_OT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n || uv_low_i)
        ($rose(fault_o) && cause_o == 2'd3) |-> ($past(ot_flag_i) && $past(temp_en_o))); // R7
    AST_UV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_low_i |=> (!fault_o && cause_o == 2'd0));                     // R10
    AST_UV_SOURCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_low_i |-> !temp_en_o);                                        // R10
endmodule

bind chg_fault_sup chg_fault_sup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .uv_low_i(uv_low_i),
    .ov_flag_i(ov_flag_i), .sock_flag_i(sock_flag_i), .ot_flag_i(ot_flag_i),
    .fault_o(fault_o), .temp_en_o(temp_en_o), .cause_o(cause_o)
);

// File: tb/sim_chg_fault_sup.sv
`timescale 1ns/1ps
module sim_chg_fault_sup;
    localparam int OVQ = 4, OVB = 10, SOQ = 20, OTQ = 4, TON = 12, TOFF = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, uv = 1'b0, tick = 1'b0;
    logic       ov = 1'b0, so = 1'b0, ot = 1'b0, clsb = 1'b0, chg = 1'b0;
    logic [2:0] lvl = 3'd0;
    logic       fault, temp_en;
    logic [1:0] thr, cause;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cov = 0, m_cso = 0, m_cot = 0, m_blk = 0, m_ph = 0, m_cause = 0;
    bit m_on = 1'b1, m_fault = 1'b0;
    bit b_blank, t_ov, t_so, t_ot;

    always #5 clk = ~clk;

    chg_fault_sup #(.OV_QUAL(OVQ), .OV_BLANK(OVB), .SOCK_QUAL(SOQ), .OT_QUAL(OTQ),
                    .TEMP_ON(TON), .TEMP_OFF(TOFF)) u0 (
        .clk(clk), .rst_n(rst_n), .uv_low_i(uv), .tick_i(tick),
        .ov_flag_i(ov), .sock_flag_i(so), .ot_flag_i(ot),
        .level_i(lvl), .class_b_i(clsb), .level_chg_i(chg),
        .fault_o(fault), .thr_sel_o(thr), .temp_en_o(temp_en), .cause_o(cause)
    );

    function automatic int exp_thr(input logic [2:0] l, input logic b);
        if (l == 3'd1) return 1;
        if (l == 3'd2) return 2;
        if (l == 3'd3) return 3;
        if (l == 3'd4) return b ? 3 : 2;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // Timebase: one tick every third cycle.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick <= ((cyc % 3) == 0);
    end

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n || uv) begin
            m_cov = 0; m_cso = 0; m_cot = 0; m_blk = 0; m_ph = 0;
            m_on = 1'b1; m_fault = 1'b0; m_cause = 0;
        end else begin
            b_blank = chg || (m_blk > 0);
            t_ov = 0; t_so = 0; t_ot = 0;
            if (!(ov && !b_blank)) m_cov = 0;
            else if (tick) begin m_cov++; t_ov = (m_cov >= OVQ); end
            if (!so) m_cso = 0;
            else if (tick) begin m_cso++; t_so = (m_cso >= SOQ); end
            if (!(ot && m_on)) m_cot = 0;
            else if (tick) begin m_cot++; t_ot = (m_cot >= OTQ); end
            if (!m_fault) begin
                if (t_ov)      begin m_fault = 1; m_cause = 1; end
                else if (t_ot) begin m_fault = 1; m_cause = 3; end
                else if (t_so) begin m_fault = 1; m_cause = 2; end
            end
            if (chg) m_blk = OVB;
            else if (tick && m_blk > 0) m_blk--;
            if (tick) begin
                m_ph++;
                if (m_on && m_ph == TON) begin m_on = 0; m_ph = 0; end
                else if (!m_on && m_ph == TOFF) begin m_on = 1; m_ph = 0; end
            end
        end
    end

    // Compare every cycle, mid low phase, after the inputs have settled.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("R9 fault", fault, m_fault);
            chk("R9 cause", cause, m_cause);
            chk("R5 thr", thr, exp_thr(lvl, clsb));
            chk("R8 temp_en", temp_en, (m_on && !uv) ? 1 : 0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        ov = 0; so = 0; ot = 0; chg = 0; uv = 0;
        rst_n = 0;
        wait_cyc(2);
        rst_n = 1;
    endtask

    initial begin
        do_reset();
        #3;
        chk("R1 fault", fault, 0);
        chk("R1 cause", cause, 0);
        chk("R1 temp_en", temp_en, 1);

        // R5: threshold map across all level codes and both classes
        for (int l = 0; l < 8; l++) begin
            for (int b = 0; b < 2; b++) begin
                lvl = 3'(l); clsb = b[0];
                #1;
                chk("R5 map", thr, exp_thr(3'(l), b[0]));
            end
        end
        lvl = 3'd0; clsb = 0;

        // R2: sustained over-voltage trips with cause 1
        do_reset(); ov = 1;
        wait_cyc(20); #3;
        chk("R2 fault", fault, 1);
        chk("R2 cause", cause, 1);
        // R9: flags drop, socket trips later, first cause is kept
        ov = 0; so = 1;
        wait_cyc(80); #3;
        chk("R9 sticky", fault, 1);
        chk("R9 first cause", cause, 1);
        so = 0;

        // R3: bursts of three ticks never reach four
        do_reset();
        for (int k = 0; k < 6; k++) begin
            ov = 1; wait_cyc(9);
            ov = 0; wait_cyc(3);
        end
        #3;
        chk("R3 no trip", fault, 0);

        // R4: blanking after a level strobe delays the over-voltage trip
        do_reset();
        lvl = 3'd1; chg = 1; ov = 1;
        wait_cyc(1); chg = 0;
        wait_cyc(29); #3;
        chk("R4 blanked", fault, 0);
        wait_cyc(20); #3;
        chk("R4 after blank", fault, 1);
        chk("R4 cause", cause, 1);
        ov = 0; lvl = 3'd0;

        // R6: socket fault trips only after its longer delay
        do_reset(); so = 1;
        wait_cyc(45); #3;
        chk("R6 early", fault, 0);
        wait_cyc(25); #3;
        chk("R6 trip", fault, 1);
        chk("R6 cause", cause, 2);
        so = 0;

        // R7/R8: over-temperature ignored while the source is off
        do_reset();
        wait_cyc(45); #3;
        chk("R8 off phase", temp_en, 0);
        ot = 1;
        wait_cyc(55); #3;
        chk("R7 ignored while off", fault, 0);
        wait_cyc(60); #3;
        chk("R7 trip", fault, 1);
        chk("R7 cause", cause, 3);
        ot = 0;

        // R9: simultaneous trips pick over-voltage over over-temperature
        do_reset(); ov = 1; ot = 1;
        wait_cyc(20); #3;
        chk("R9 priority", cause, 1);
        ov = 0; ot = 0;

        // R10: undervoltage clears the latched fault and holds the source off
        uv = 1;
        wait_cyc(1); #3;
        chk("R10 fault", fault, 0);
        chk("R10 cause", cause, 0);
        chk("R10 temp_en", temp_en, 0);
        uv = 0;
        wait_cyc(5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule